// File: doc/BRIEF.md
# ADC Regular-Sequence Conversion Controller

This block is the digital control core of a multiplexed successive-approximation converter. Software loads a list of channel numbers into sequence slots and gives each channel a 3-bit sampling-time code. It also picks a resolution, a bus-clock prescale and whether the whole list or only its first slot is converted. A one-cycle start request then makes the controller walk the list. For each slot it drives the channel select, holds the sample strobe for the programmed sampling window and then holds the convert strobe for a resolution-dependent conversion window.

Both windows are counted in converter clock periods. A converter clock period is a fixed number of bus clock cycles, chosen by the prescale code. At the end of each conversion the controller takes the code presented by the analog front end, masks it to the active resolution, and stores it in a result register that the bus can only read. It then raises an end-of-conversion flag, which a read strobe clears.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is asserted and right after it, busy, both strobes, the end-of-conversion flag, the channel select and the result register are all zero.
- R2: When idle, the channel select reads zero and both strobes are low. A start request while idle makes busy and the sample strobe high from the next cycle, with the channel select showing the channel held in slot 0.
- R3: The sample strobe lasts S times the prescale bus cycles. S comes from the channel's code as follows: 0→3, 1→15, 2→28, 3→56, 4→84, 5→112, 6→144, 7→480. The code of channel c sits at bits [3c+2:3c] of the code vector. The channel of slot s sits at bits [5s+4:5s] of the slot vector.
- R4: The convert strobe follows the sample strobe at once and lasts C times the prescale bus cycles. C is 15, 13, 11 or 9 for resolution codes 00, 01, 10 and 11 (12, 10, 8 and 6 bits).
- R5: Prescale codes 00, 01, 10 and 11 make one converter clock period last 2, 4, 6 and 8 bus cycles. The total busy time of a run is the sum of (S+C) times that divisor over the converted slots.
- R6: In the cycle that ends a conversion, the input code is captured into the result register, right-aligned and masked to the low 12, 10, 8 or 6 bits. The end-of-conversion flag is set from the next cycle.
- R7: With scan disabled, only slot 0 is converted, whatever the length field holds.
- R8: With scan enabled and length field L (the count minus one), slots 0 to L are converted in order. The flag is set after each one, and the controller returns to idle after slot L.
- R9: A start request arriving while a run is in progress has no effect on the run.
- R10: A read strobe clears the end-of-conversion flag. If the read strobe falls in the same cycle as a conversion completing, the flag stays set.
- R11: The result register changes only in a cycle that completes a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Software start request, one cycle |
| scan_en_i | input | 1 | 1: run all slots up to the length; 0: slot 0 only |
| res_i | input | 2 | Resolution code |
| presc_i | input | 2 | Converter clock prescale code |
| seq_len_i | input | 4 | Number of slots minus one |
| seq_slots_i | input | 80 | Sixteen 5-bit channel numbers, slot s at [5s+4:5s] |
| smp_codes_i | input | 57 | Nineteen 3-bit sampling codes, channel c at [3c+2:3c] |
| conv_code_i | input | 12 | Code from the analog front end |
| rd_i | input | 1 | Result read strobe |
| mux_sel_o | output | 5 | Channel select for the analog multiplexer |
| sample_o | output | 1 | Sample strobe |
| convert_o | output | 1 | Convert strobe |
| busy_o | output | 1 | A run is in progress |
| eoc_o | output | 1 | End-of-conversion flag |
| data_o | output | 12 | Read-only result register |

## Verification
Two events can land on the same clock edge: a read strobe clearing the end-of-conversion flag, and a conversion completing and setting it. To make them meet, one run holds the read strobe high for its whole length, so the strobe is present at every completion edge. That run is judged by a per-cycle reference model and by a direct check that the flag is high right after the final completion. The second collision is a fresh start request arriving mid-run. The bench compares the total busy time and the order of the channels sampled against values computed from the sampling and conversion tables.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int RES_W  = 12;
    localparam int SMP_W  = 3;
    localparam int TCNT_W = 9;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SAMPLE  = 2'd1,
        PH_CONVERT = 2'd2
    } phase_t;

    function automatic logic [TCNT_W-1:0] smp_len(input logic [SMP_W-1:0] code);
        case (code)
            3'd0:    return 9'd3;
            3'd1:    return 9'd15;
            3'd2:    return 9'd28;
            3'd3:    return 9'd56;
            3'd4:    return 9'd84;
            3'd5:    return 9'd112;
            3'd6:    return 9'd144;
            default: return 9'd480;
        endcase
    endfunction

    function automatic logic [TCNT_W-1:0] conv_len(input logic [1:0] res);
        case (res)
            2'd0:    return 9'd15;
            2'd1:    return 9'd13;
            2'd2:    return 9'd11;
            default: return 9'd9;
        endcase
    endfunction

    function automatic logic [3:0] div_of(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd2;
            2'd1:    return 4'd4;
            2'd2:    return 4'd6;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic [RES_W-1:0] res_mask(input logic [1:0] res);
        case (res)
            2'd0:    return 12'hFFF;
            2'd1:    return 12'h3FF;
            2'd2:    return 12'h0FF;
            default: return 12'h03F;
        endcase
    endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div
    import adc_seq_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [1:0] code_i,
    output logic       tick_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t          div_q, div_d;
    logic [DIV_W-1:0] last_d;

    always_comb begin
        div_d  = div_q;
        last_d = DIV_W'(div_of(code_i)) - 1'b1;
        tick_o = en_i && (div_q.cnt == last_d);
        if (!en_i || tick_o) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    AST_DIV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tick_o) |=> (div_q.cnt == DIV_W'($past(div_q.cnt) + 1'b1))); // R5
    AST_DIV_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (div_q.cnt == '0)); // R5

endmodule

// File: rtl/adc_slot_pick.sv
module adc_slot_pick
    import adc_seq_pkg::*;
#(
    parameter int SLOTS = 16,
    parameter int NCH   = 19,
    parameter int CH_W  = 5,
    parameter int LEN_W = 4
) (
    input  logic [SLOTS*CH_W-1:0] slots_i,
    input  logic [NCH*SMP_W-1:0]  codes_i,
    input  logic [LEN_W-1:0]      idx_i,
    output logic [CH_W-1:0]       ch_o,
    output logic [SMP_W-1:0]      code_o
);

    localparam int NSEL = 1 << CH_W;

    logic [CH_W-1:0]  slot_a [SLOTS];
    logic [SMP_W-1:0] code_a [NSEL];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign slot_a[s] = slots_i[s*CH_W +: CH_W];
    end

    for (genvar c = 0; c < NSEL; c++) begin : g_code
        if (c < NCH) begin : g_real
            assign code_a[c] = codes_i[c*SMP_W +: SMP_W];
        end else begin : g_pad
            assign code_a[c] = '0;
        end
    end

    assign ch_o   = slot_a[idx_i];
    assign code_o = code_a[ch_o];

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              start_i,
    input  logic              scan_en_i,
    input  logic [1:0]        res_i,
    input  logic [LEN_W-1:0]  seq_len_i,
    input  logic [SMP_W-1:0]  smp_code_i,
    input  logic [RES_W-1:0]  conv_code_i,
    input  logic              rd_i,
    output logic [LEN_W-1:0]  idx_o,
    output logic              busy_o,
    output logic              sample_o,
    output logic              convert_o,
    output logic              eoc_o,
    output logic [RES_W-1:0]  data_o
);

    typedef struct packed {
        phase_t              phase;
        logic [LEN_W-1:0]    idx;
        logic [TCNT_W-1:0]   tcnt;
        logic                eoc;
        logic [RES_W-1:0]    data;
    } seq_st_t;

    seq_st_t           seq_q, seq_d;
    logic              fin;
    logic [TCNT_W-1:0] lim;

    always_comb begin
        seq_d = seq_q;
        fin   = 1'b0;
        lim   = (seq_q.phase == PH_SAMPLE) ? smp_len(smp_code_i) - 1'b1
                                           : conv_len(res_i) - 1'b1;
        case (seq_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    seq_d.phase = PH_SAMPLE;
                    seq_d.idx   = '0;
                    seq_d.tcnt  = '0;
                end
            end
            PH_SAMPLE: begin
                if (tick_i) begin
                    if (seq_q.tcnt == lim) begin
                        seq_d.phase = PH_CONVERT;
                        seq_d.tcnt  = '0;
                    end else begin
                        seq_d.tcnt = seq_q.tcnt + 1'b1;
                    end
                end
            end
            PH_CONVERT: begin
                if (tick_i) begin
                    if (seq_q.tcnt == lim) begin
                        fin        = 1'b1;
                        seq_d.data = conv_code_i & res_mask(res_i);
                        seq_d.tcnt = '0;
                        if (scan_en_i && (seq_q.idx < seq_len_i)) begin
                            seq_d.idx   = seq_q.idx + 1'b1;
                            seq_d.phase = PH_SAMPLE;
                        end else begin
                            seq_d.phase = PH_IDLE;
                        end
                    end else begin
                        seq_d.tcnt = seq_q.tcnt + 1'b1;
                    end
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
        seq_d.eoc = fin | (seq_q.eoc & ~rd_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign idx_o     = seq_q.idx;
    assign busy_o    = (seq_q.phase != PH_IDLE);
    assign sample_o  = (seq_q.phase == PH_SAMPLE);
    assign convert_o = (seq_q.phase == PH_CONVERT);
    assign eoc_o     = seq_q.eoc;
    assign data_o    = seq_q.data;

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_IDLE && !start_i) |=> (seq_q.phase == PH_IDLE)); // R2
    AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase != PH_IDLE && !tick_i) |=> (seq_q.phase == $past(seq_q.phase))); // R5
    AST_EOC_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> seq_q.eoc); // R6
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> $stable(seq_q.data)); // R11
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !fin) |=> !seq_q.eoc); // R10
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase != PH_IDLE) |-> (seq_q.idx <= seq_len_i)); // R8
    AST_START_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase != PH_IDLE && start_i && !tick_i) |=> (seq_q.idx == $past(seq_q.idx))); // R9

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter  int SLOTS = 16,
    parameter  int NCH   = 19,
    localparam int CH_W  = $clog2(NCH),
    localparam int LEN_W = $clog2(SLOTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  scan_en_i,
    input  logic [1:0]            res_i,
    input  logic [1:0]            presc_i,
    input  logic [LEN_W-1:0]      seq_len_i,
    input  logic [SLOTS*CH_W-1:0] seq_slots_i,
    input  logic [NCH*SMP_W-1:0]  smp_codes_i,
    input  logic [RES_W-1:0]      conv_code_i,
    input  logic                  rd_i,
    output logic [CH_W-1:0]       mux_sel_o,
    output logic                  sample_o,
    output logic                  convert_o,
    output logic                  busy_o,
    output logic                  eoc_o,
    output logic [RES_W-1:0]      data_o
);

    logic [LEN_W-1:0] idx;
    logic [CH_W-1:0]  ch;
    logic [SMP_W-1:0] smp_code;
    logic             tick;
    logic             busy;

    adc_slot_pick #(
        .SLOTS (SLOTS),
        .NCH   (NCH),
        .CH_W  (CH_W),
        .LEN_W (LEN_W)
    ) u_pick (
        .slots_i (seq_slots_i),
        .codes_i (smp_codes_i),
        .idx_i   (idx),
        .ch_o    (ch),
        .code_o  (smp_code)
    );

    adc_clk_div #(
        .DIV_W (4)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (busy),
        .code_i (presc_i),
        .tick_o (tick)
    );

    adc_seq_fsm #(
        .LEN_W (LEN_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .start_i     (start_i),
        .scan_en_i   (scan_en_i),
        .res_i       (res_i),
        .seq_len_i   (seq_len_i),
        .smp_code_i  (smp_code),
        .conv_code_i (conv_code_i),
        .rd_i        (rd_i),
        .idx_o       (idx),
        .busy_o      (busy),
        .sample_o    (sample_o),
        .convert_o   (convert_o),
        .eoc_o       (eoc_o),
        .data_o      (data_o)
    );

    assign busy_o    = busy;
    assign mux_sel_o = busy ? ch : '0;

    AST_SEL_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (mux_sel_o == '0 && !sample_o && !convert_o)); // R2

endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int SLOTS = 16;
    localparam int NCH   = 19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        scan_en_i = 1'b0;
    logic [1:0]  res_i = '0;
    logic [1:0]  presc_i = '0;
    logic [3:0]  seq_len_i = '0;
    logic [79:0] seq_slots_i = '0;
    logic [56:0] smp_codes_i = '0;
    logic [11:0] conv_code_i = '0;
    logic        rd_i = 1'b0;
    logic [4:0]  mux_sel_o;
    logic        sample_o, convert_o, busy_o, eoc_o;
    logic [11:0] data_o;

    adc_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .scan_en_i(scan_en_i),
        .res_i(res_i), .presc_i(presc_i), .seq_len_i(seq_len_i),
        .seq_slots_i(seq_slots_i), .smp_codes_i(smp_codes_i),
        .conv_code_i(conv_code_i), .rd_i(rd_i), .mux_sel_o(mux_sel_o),
        .sample_o(sample_o), .convert_o(convert_o), .busy_o(busy_o),
        .eoc_o(eoc_o), .data_o(data_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int samp_tab [8] = '{3, 15, 28, 56, 84, 112, 144, 480};

    int slot_ch  [SLOTS];
    int smp_code [NCH];
    int rd_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    int obs_ch [$];
    int busy_cnt = 0;
    logic prev_sample = 1'b0;

    // reference model state
    int m_busy = 0, m_phase = 0, m_rem = 0, m_idx = 0, m_eoc = 0, m_data = 0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int div_n();
        return 2 * (int'(presc_i) + 1);
    endfunction

    function automatic int conv_n();
        return 15 - 2 * int'(res_i);
    endfunction

    function automatic int smp_n(input int ch);
        return samp_tab[smp_code[ch]];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_phase = 0; m_rem = 0; m_idx = 0; m_eoc = 0; m_data = 0;
        end else begin
            int fin;
            fin = 0;
            if (m_busy == 0) begin
                if (start_i) begin
                    m_busy = 1; m_phase = 0; m_idx = 0;
                    m_rem = smp_n(slot_ch[0]) * div_n();
                end
            end else begin
                m_rem--;
                if (m_rem == 0) begin
                    if (m_phase == 0) begin
                        m_phase = 1;
                        m_rem = conv_n() * div_n();
                    end else begin
                        fin = 1;
                        m_data = int'(conv_code_i) & ((1 << (12 - 2 * int'(res_i))) - 1);
                        if (scan_en_i && m_idx < int'(seq_len_i)) begin
                            m_idx++;
                            m_phase = 0;
                            m_rem = smp_n(slot_ch[m_idx]) * div_n();
                        end else begin
                            m_busy = 0;
                        end
                    end
                end
            end
            m_eoc = fin ? 1 : ((m_eoc != 0 && !rd_i) ? 1 : 0);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R8 busy", int'(busy_o), m_busy);
            check("R3 sample strobe", int'(sample_o), (m_busy != 0 && m_phase == 0) ? 1 : 0);
            check("R4 convert strobe", int'(convert_o), (m_busy != 0 && m_phase == 1) ? 1 : 0);
            check("R2 channel select", int'(mux_sel_o), (m_busy != 0) ? slot_ch[m_idx] : 0);
            check("R10 eoc flag", int'(eoc_o), m_eoc);
            check("R6 R11 result", int'(data_o), m_data);
            if (busy_o) busy_cnt++;
            if (sample_o && !prev_sample) obs_ch.push_back(int'(mux_sel_o));
            prev_sample = sample_o;
        end
    end

    task automatic apply_cfg();
        for (int s = 0; s < SLOTS; s++) seq_slots_i[s*5 +: 5] = 5'(slot_ch[s]);
        for (int c = 0; c < NCH; c++) smp_codes_i[c*3 +: 3] = 3'(smp_code[c]);
    endtask

    task automatic step();
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        conv_code_i = lfsr[11:0];
        case (rd_mode)
            1:       rd_i = lfsr[3] & lfsr[7];
            2:       rd_i = 1'b1;
            default: rd_i = 1'b0;
        endcase
    endtask

    task automatic run_case(input string tag, input int rmode);
        int n, exp_cyc, exp_ch [$], guard;
        apply_cfg();
        rd_mode = rmode;
        n = scan_en_i ? int'(seq_len_i) + 1 : 1;
        exp_cyc = 0;
        for (int k = 0; k < n; k++) begin
            exp_ch.push_back(slot_ch[k]);
            exp_cyc += (smp_n(slot_ch[k]) + conv_n()) * div_n();
        end
        obs_ch.delete();
        busy_cnt = 0;
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        repeat (5) step();
        start_i = 1'b1;            // R9: request while running
        step();
        start_i = 1'b0;
        guard = 0;
        while (busy_o && guard < 100000) begin
            step();
            guard++;
        end
        if (rmode == 2) check({"R10 flag kept on coincident read ", tag}, int'(eoc_o), 1);
        check({"R5 busy cycles ", tag}, busy_cnt, exp_cyc);
        check({"R8 R7 slots converted ", tag}, obs_ch.size(), n);
        for (int k = 0; k < n && k < obs_ch.size(); k++)
            check({"R8 channel order ", tag}, obs_ch[k], exp_ch[k]);
        rd_mode = 0;
        repeat (3) step();
    endtask

    initial begin
        for (int s = 0; s < SLOTS; s++) slot_ch[s] = 0;
        for (int c = 0; c < NCH; c++) smp_code[c] = 0;
        apply_cfg();
        repeat (3) @(negedge clk);
        check("R1 busy in reset", int'(busy_o), 0);
        check("R1 eoc in reset", int'(eoc_o), 0);
        check("R1 result in reset", int'(data_o), 0);
        check("R1 strobes in reset", int'(sample_o | convert_o), 0);
        check("R1 select in reset", int'(mux_sel_o), 0);
        rst_n = 1'b1;
        repeat (2) step();

        // R7: scan off, length ignored
        scan_en_i = 1'b0; seq_len_i = 4'd3; res_i = 2'd0; presc_i = 2'd0;
        slot_ch[0] = 5; slot_ch[1] = 9; slot_ch[2] = 2; slot_ch[3] = 4;
        smp_code[5] = 0;
        run_case("scan off", 1);

        // R8 R3 R4: scan across four slots
        scan_en_i = 1'b1; seq_len_i = 4'd3; res_i = 2'd1; presc_i = 2'd1;
        slot_ch[0] = 1; slot_ch[1] = 18; slot_ch[2] = 7; slot_ch[3] = 2;
        smp_code[1] = 1; smp_code[18] = 2; smp_code[7] = 3; smp_code[2] = 6;
        run_case("scan four", 1);

        // R10: read held high across every completion
        scan_en_i = 1'b1; seq_len_i = 4'd3; res_i = 2'd2; presc_i = 2'd2;
        slot_ch[0] = 0; slot_ch[1] = 3; slot_ch[2] = 3; slot_ch[3] = 10;
        smp_code[0] = 4; smp_code[3] = 0; smp_code[10] = 5;
        run_case("read held", 2);

        // R3 R5: longest sample code, slowest prescale, 6-bit result
        scan_en_i = 1'b0; seq_len_i = 4'd0; res_i = 2'd3; presc_i = 2'd3;
        slot_ch[0] = 12; smp_code[12] = 7;
        run_case("long sample", 0);
        check("R10 flag stays without read", int'(eoc_o), 1);
        rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
        check("R10 flag cleared by read", int'(eoc_o), 0);

        // R8: all sixteen slots
        scan_en_i = 1'b1; seq_len_i = 4'd15; res_i = 2'd0; presc_i = 2'd0;
        for (int s = 0; s < SLOTS; s++) slot_ch[s] = (s * 5) % NCH;
        for (int c = 0; c < NCH; c++) smp_code[c] = c % 3;
        run_case("full list", 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule